// File: doc/BRIEF.md
# Double-Rate Write Data Capture with Byte Masks

This block takes write data arriving at twice the clock rate and packs it into internal words twice as wide as the external data bus. The double-rate timing is modelled in one clock domain: in each clock the block is offered a first-edge beat and a second-edge beat. Each beat has its own valid flag, a 16-bit data word and a 2-bit byte mask. Accepted beats are paired in arrival order to form one 32-bit word. The byte enables of that word come from the inverted masks.

A write command opens a capture window for a programmed number of beats. The window starts one clock after the command, which models a write latency of one clock. Beats that fall outside a window are ignored, so data and masks seen on the bus during reads or idle time have no effect. A burst stop or a new write command closes the window early. If that leaves a half-assembled word, the word is thrown away and a one-cycle error pulse is raised. Each emitted word carries its position within the burst.

Top module: `ddrw_capture`

## Requirements
- R1: While reset is applied, `word_vld` and `frag_err` are low and no capture window is open.
- R2: A beat is accepted only inside a window that opens in the clock after `wr_cmd`. Beats in the command clock itself, and beats when no window is open, produce no output.
- R3: Accepted beats are paired in order, with the first-edge beat of a clock taken before its second-edge beat. The earlier beat of a pair fills `word_data[15:0]` and the later beat fills `word_data[31:16]`. A pair may span two clocks.
- R4: `word_be[0]` and `word_be[1]` are the inverted mask bits 0 and 1 of the earlier beat, and `word_be[2]` and `word_be[3]` are those of the later beat. Mask bit 0 covers data bits 7:0 and mask bit 1 covers data bits 15:8. A mask bit of 1 blocks its byte.
- R5: `bl_sel` gives the window length: 0 means 2 beats, 1 means 4 beats, and 2 or 3 means 8 beats. After that many beats the window closes, and any further beats are ignored.
- R6: `word_idx` is 0 for the first word of a burst and goes up by one for each later word.
- R7: `word_vld` is a one-cycle pulse in the clock after the clock in which the completing beat was presented.
- R8: When `wr_cmd` comes during an open window, beats in that same clock still count toward the old burst, and then the old burst ends. If a half word is left over, it is discarded and `frag_err` pulses in the next clock. Back-to-back complete bursts raise no error.
- R9: `stop_cmd` closes the window after the beats of its own clock have been counted, with the same discard and error rule as R8. Later beats produce no output.
- R10: When `wr_cmd` and `stop_cmd` come in the same clock, the write takes priority and a new window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_cmd | input | 1 | Write command; opens a window from the next clock |
| stop_cmd | input | 1 | Burst stop; closes the window |
| bl_sel | input | 2 | Burst length select, sampled with `wr_cmd` |
| rise_vld | input | 1 | First-edge beat valid |
| rise_dq | input | 16 | First-edge beat data |
| rise_dm | input | 2 | First-edge beat byte masks (1 = blocked) |
| fall_vld | input | 1 | Second-edge beat valid |
| fall_dq | input | 16 | Second-edge beat data |
| fall_dm | input | 2 | Second-edge beat byte masks (1 = blocked) |
| word_vld | output | 1 | Assembled word valid |
| word_data | output | 32 | Assembled word, earlier beat in the low half |
| word_be | output | 4 | Byte enables of the word (1 = write) |
| word_idx | output | 2 | Word position within the burst |
| frag_err | output | 1 | Pulse: a half-assembled word was discarded |

## Verification
The pairing logic is exercised with several beat patterns:
- Full-rate traffic, where both edges carry a beat in every clock, confirms the simple pairing within one clock.
- Beats arriving only on the second edge followed by the first edge of the next clock confirm that pairing follows beat order, not clock boundaries.
- Overfilled windows, and beats placed in the command clock, show exactly where the window opens and closes.

Early termination is tried in three ways:
- A stop or a write after an odd number of beats separates the discard path from an even-count stop, which must stay silent.
- A simultaneous write and stop tests the priority between them.
- Distinct mask values on each byte of each beat catch a swapped lane or a swapped half.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;
  typedef enum logic [1:0] {
    BURST_2  = 2'd0,
    BURST_4  = 2'd1,
    BURST_8  = 2'd2,
    BURST_8B = 2'd3
  } burst_sel_e;
endpackage

// File: rtl/ddrw_rst_sync.sv
module ddrw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/ddrw_burst_ctrl.sv
module ddrw_burst_ctrl #(
  parameter int MAX_BL = 8,
  localparam int CNT_W = $clog2(MAX_BL + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic       stop_cmd,
  input  logic [1:0] bl_sel,
  input  logic       rise_vld,
  input  logic       fall_vld,
  output logic       acc_rise,
  output logic       acc_fall,
  output logic       win_open
);
  import ddrw_pkg::*;

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] left_d;
  logic [CNT_W-1:0] load_len;
  logic             left_en;

  always_comb begin
    case (burst_sel_e'(bl_sel))
      BURST_2: load_len = CNT_W'(MAX_BL / 4);
      BURST_4: load_len = CNT_W'(MAX_BL / 2);
      default: load_len = CNT_W'(MAX_BL);
    endcase
  end

  assign win_open = (left_q != '0);
  assign acc_rise = rise_vld && win_open;
  assign acc_fall = fall_vld && (left_q > CNT_W'(acc_rise));

  always_comb begin
    left_d = left_q - CNT_W'(acc_rise) - CNT_W'(acc_fall);
    if (wr_cmd) begin
      left_d = load_len;
    end else if (stop_cmd) begin
      left_d = '0;
    end
    left_en = wr_cmd || stop_cmd || acc_rise || acc_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/ddrw_lane_en.sv
module ddrw_lane_en #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] enable
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign enable[g] = ~mask[g];
  end
endmodule

// File: rtl/ddrw_pairer.sv
module ddrw_pairer #(
  parameter int DQ_W   = 16,
  parameter int LANE_W = 8,
  parameter int IDX_W  = 2,
  localparam int DM_W  = DQ_W / LANE_W,
  localparam int WD_W  = 2 * DQ_W,
  localparam int BE_W  = 2 * DM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_rise,
  input  logic [DQ_W-1:0]  rise_dq,
  input  logic [DM_W-1:0]  rise_dm,
  input  logic             acc_fall,
  input  logic [DQ_W-1:0]  fall_dq,
  input  logic [DM_W-1:0]  fall_dm,
  input  logic             restart,
  input  logic             flush,
  output logic             word_vld,
  output logic [WD_W-1:0]  word_data,
  output logic [BE_W-1:0]  word_be,
  output logic [IDX_W-1:0] word_idx,
  output logic             frag_err
);
  logic             pend_v_q, pend_v_d;
  logic [DQ_W-1:0]  pend_dq_q, pend_dq_d;
  logic [DM_W-1:0]  pend_dm_q, pend_dm_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             mk_v;
  logic [WD_W-1:0]  mk_data;
  logic [BE_W-1:0]  mk_mask;
  logic [BE_W-1:0]  mk_be;
  logic             err_d;
  logic             vld_q, err_q;
  logic [WD_W-1:0]  data_q;
  logic [BE_W-1:0]  be_q;
  logic [IDX_W-1:0] oidx_q;
  logic             pend_en;

  always_comb begin
    pend_v_d  = pend_v_q;
    pend_dq_d = pend_dq_q;
    pend_dm_d = pend_dm_q;
    mk_v      = 1'b0;
    mk_data   = '0;
    mk_mask   = '0;
    if (acc_rise) begin
      if (pend_v_d) begin
        mk_v     = 1'b1;
        mk_data  = {rise_dq, pend_dq_d};
        mk_mask  = {rise_dm, pend_dm_d};
        pend_v_d = 1'b0;
      end else begin
        pend_v_d  = 1'b1;
        pend_dq_d = rise_dq;
        pend_dm_d = rise_dm;
      end
    end
    if (acc_fall) begin
      if (pend_v_d) begin
        mk_v     = 1'b1;
        mk_data  = {fall_dq, pend_dq_d};
        mk_mask  = {fall_dm, pend_dm_d};
        pend_v_d = 1'b0;
      end else begin
        pend_v_d  = 1'b1;
        pend_dq_d = fall_dq;
        pend_dm_d = fall_dm;
      end
    end
    err_d = flush && pend_v_d;
    if (flush) begin
      pend_v_d = 1'b0;
    end
    pend_en = acc_rise || acc_fall || flush;
  end

  always_comb begin
    idx_d = idx_q;
    if (mk_v) begin
      idx_d = idx_q + IDX_W'(1);
    end
    if (restart) begin
      idx_d = '0;
    end
  end

  ddrw_lane_en #(.LANES(BE_W)) u_lane_en (
    .mask   (mk_mask),
    .enable (mk_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q  <= 1'b0;
      pend_dq_q <= '0;
      pend_dm_q <= '0;
      idx_q     <= '0;
      vld_q     <= 1'b0;
      err_q     <= 1'b0;
      data_q    <= '0;
      be_q      <= '0;
      oidx_q    <= '0;
    end else begin
      vld_q <= mk_v;
      err_q <= err_d;
      idx_q <= idx_d;
      if (pend_en) begin
        pend_v_q  <= pend_v_d;
        pend_dq_q <= pend_dq_d;
        pend_dm_q <= pend_dm_d;
      end
      if (mk_v) begin
        data_q <= mk_data;
        be_q   <= mk_be;
        oidx_q <= idx_q;
      end
    end
  end

  assign word_vld  = vld_q;
  assign word_data = data_q;
  assign word_be   = be_q;
  assign word_idx  = oidx_q;
  assign frag_err  = err_q;
endmodule

// File: rtl/ddrw_capture.sv
module ddrw_capture #(
  parameter int DQ_W   = 16,
  parameter int LANE_W = 8,
  parameter int MAX_BL = 8,
  localparam int DM_W  = DQ_W / LANE_W,
  localparam int IDX_W = $clog2(MAX_BL / 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cmd,
  input  logic                 stop_cmd,
  input  logic [1:0]           bl_sel,
  input  logic                 rise_vld,
  input  logic [DQ_W-1:0]      rise_dq,
  input  logic [DM_W-1:0]      rise_dm,
  input  logic                 fall_vld,
  input  logic [DQ_W-1:0]      fall_dq,
  input  logic [DM_W-1:0]      fall_dm,
  output logic                 word_vld,
  output logic [2*DQ_W-1:0]    word_data,
  output logic [2*DM_W-1:0]    word_be,
  output logic [IDX_W-1:0]     word_idx,
  output logic                 frag_err
);
  logic srst_n;
  logic acc_rise;
  logic acc_fall;
  logic win_open;

  ddrw_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ddrw_burst_ctrl #(.MAX_BL(MAX_BL)) u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_cmd   (wr_cmd),
    .stop_cmd (stop_cmd),
    .bl_sel   (bl_sel),
    .rise_vld (rise_vld),
    .fall_vld (fall_vld),
    .acc_rise (acc_rise),
    .acc_fall (acc_fall),
    .win_open (win_open)
  );

  ddrw_pairer #(.DQ_W(DQ_W), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_pair (
    .clk       (clk),
    .rst_n     (srst_n),
    .acc_rise  (acc_rise),
    .rise_dq   (rise_dq),
    .rise_dm   (rise_dm),
    .acc_fall  (acc_fall),
    .fall_dq   (fall_dq),
    .fall_dm   (fall_dm),
    .restart   (wr_cmd),
    .flush     (wr_cmd || stop_cmd),
    .word_vld  (word_vld),
    .word_data (word_data),
    .word_be   (word_be),
    .word_idx  (word_idx),
    .frag_err  (frag_err)
  );
endmodule

// File: rtl/ddrw_capture_chk.sv
module ddrw_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_cmd,
  input logic stop_cmd,
  input logic rise_vld,
  input logic fall_vld,
  input logic win_open,
  input logic word_vld,
  input logic frag_err
);
  // R8 / R9: a discard pulse only follows a write or stop clock
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frag_err |-> $past(wr_cmd || stop_cmd));

  // R2: a word can only come from a clock where the window was open
  assert_word_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(win_open));

  // R3: a word is always completed by a beat presented in the prior clock
  assert_word_from_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(rise_vld || fall_vld));

  // R9: after a plain stop, the following clock's beats make no word
  assert_stop_silence_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd && !wr_cmd) |-> ##2 !word_vld);
endmodule

bind ddrw_capture ddrw_capture_chk u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .wr_cmd   (wr_cmd),
  .stop_cmd (stop_cmd),
  .rise_vld (rise_vld),
  .fall_vld (fall_vld),
  .win_open (win_open),
  .word_vld (word_vld),
  .frag_err (frag_err)
);

// File: tb/ddrw_capture_test.sv
`timescale 1ns/1ps
module ddrw_capture_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_cmd, stop_cmd;
  logic [1:0]  bl_sel;
  logic        rise_vld, fall_vld;
  logic [15:0] rise_dq, fall_dq;
  logic [1:0]  rise_dm, fall_dm;
  logic        word_vld, frag_err;
  logic [31:0] word_data;
  logic [3:0]  word_be;
  logic [1:0]  word_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int          m_left = 0;
  int          m_idx  = 0;
  logic [17:0] pq[$];
  bit          e_vld, e_err;
  logic [31:0] e_data;
  logic [3:0]  e_be;
  logic [1:0]  e_idx;

  always #5 clk = ~clk;

  ddrw_capture uut (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .stop_cmd(stop_cmd),
    .bl_sel(bl_sel), .rise_vld(rise_vld), .rise_dq(rise_dq), .rise_dm(rise_dm),
    .fall_vld(fall_vld), .fall_dq(fall_dq), .fall_dm(fall_dm),
    .word_vld(word_vld), .word_data(word_data), .word_be(word_be),
    .word_idx(word_idx), .frag_err(frag_err)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic accept(input bit v, input logic [15:0] d, input logic [1:0] m);
    logic [17:0] b;
    if (v && m_left > 0) begin
      m_left--;
      if (pq.size() == 1) begin
        b      = pq.pop_front();
        e_vld  = 1;
        e_data = {d, b[15:0]};
        e_be   = {~m, ~b[17:16]};
        e_idx  = 2'(m_idx);
        m_idx++;
      end else begin
        pq.push_back({m, d});
      end
    end
  endtask

  task automatic step(input bit wr, input bit stp, input logic [1:0] bl,
                      input bit rv, input logic [15:0] rd, input logic [1:0] rm,
                      input bit fv, input logic [15:0] fd, input logic [1:0] fm,
                      input string tag);
    wr_cmd = wr; stop_cmd = stp; bl_sel = bl;
    rise_vld = rv; rise_dq = rd; rise_dm = rm;
    fall_vld = fv; fall_dq = fd; fall_dm = fm;
    e_vld = 0; e_err = 0;
    accept(rv, rd, rm);
    accept(fv, fd, fm);
    if (wr || stp) begin
      if (pq.size() != 0) e_err = 1;
      pq.delete();
      m_left = 0;
    end
    if (wr) begin
      m_left = (bl == 2'd0) ? 2 : (bl == 2'd1) ? 4 : 8;
      m_idx  = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(word_vld == e_vld, tag, "word_vld", 64'(word_vld), 64'(e_vld));
    check(frag_err == e_err, tag, "frag_err", 64'(frag_err), 64'(e_err));
    if (e_vld) begin
      check(word_data == e_data && word_be == e_be && word_idx == e_idx, tag,
            "data/be/idx", {26'd0, word_idx, word_be, word_data},
            {26'd0, e_idx, e_be, e_data});
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 16'h0, 2'b0, 0, 16'h0, 2'b0, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_cmd = 0; stop_cmd = 0; bl_sel = 0;
    rise_vld = 0; fall_vld = 0; rise_dq = 0; fall_dq = 0; rise_dm = 0; fall_dm = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(word_vld == 0 && frag_err == 0, "R1", "reset outputs",
          64'({word_vld, frag_err}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: beats with no window (e.g. read traffic) are ignored
    step(0, 0, 0, 1, 16'hDEAD, 2'b11, 1, 16'hBEEF, 2'b00, "R2");
    step(0, 0, 0, 1, 16'h1111, 2'b00, 1, 16'h2222, 2'b00, "R2");
    // R2: beats in the command clock ignored; R3/R4/R7 single word BL2
    step(1, 0, 2'd0, 1, 16'hAAAA, 2'b00, 1, 16'hBBBB, 2'b00, "R2");
    step(0, 0, 0, 1, 16'h1234, 2'b01, 1, 16'h5678, 2'b10, "R4");
    idle("R7");
    // R5/R6: BL8 at full rate, idx 0..3
    step(1, 0, 2'd2, 0, 16'h0, 2'b0, 0, 16'h0, 2'b0, "R5");
    step(0, 0, 0, 1, 16'h0101, 2'b00, 1, 16'h0202, 2'b11, "R6");
    step(0, 0, 0, 1, 16'h0303, 2'b10, 1, 16'h0404, 2'b01, "R6");
    step(0, 0, 0, 1, 16'h0505, 2'b11, 1, 16'h0606, 2'b00, "R6");
    step(0, 0, 0, 1, 16'h0707, 2'b01, 1, 16'h0808, 2'b01, "R6");
    step(0, 0, 0, 1, 16'h0909, 2'b00, 1, 16'h0A0A, 2'b00, "R5");
    idle("R5");
    // R3: BL4 with pairs spanning clocks, then surplus beats ignored (R5)
    step(1, 0, 2'd1, 0, 16'h0, 2'b0, 0, 16'h0, 2'b0, "R3");
    step(0, 0, 0, 0, 16'h0, 2'b0, 1, 16'hC001, 2'b01, "R3");
    step(0, 0, 0, 1, 16'hC002, 2'b10, 1, 16'hC003, 2'b00, "R3");
    step(0, 0, 0, 1, 16'hC004, 2'b11, 1, 16'hC005, 2'b00, "R5");
    step(0, 0, 0, 1, 16'hC006, 2'b00, 1, 16'hC007, 2'b00, "R5");
    // R8: back-to-back BL2 writes, no error
    step(1, 0, 2'd0, 0, 16'h0, 2'b0, 0, 16'h0, 2'b0, "R8");
    step(1, 0, 2'd0, 1, 16'hE001, 2'b00, 1, 16'hE002, 2'b00, "R8");
    step(0, 0, 0, 1, 16'hE003, 2'b10, 1, 16'hE004, 2'b01, "R8");
    idle("R8");
    // R8: new write with a half word left: discard and error
    step(1, 0, 2'd1, 0, 16'h0, 2'b0, 0, 16'h0, 2'b0, "R8");
    step(0, 0, 0, 1, 16'hF001, 2'b00, 1, 16'hF002, 2'b00, "R8");
    step(1, 0, 2'd0, 1, 16'hF003, 2'b00, 0, 16'h0, 2'b0, "R8");
    step(0, 0, 0, 1, 16'hF004, 2'b00, 1, 16'hF005, 2'b11, "R6");
    idle("R8");
    // R9: stop after odd count, later beats ignored
    step(1, 0, 2'd2, 0, 16'h0, 2'b0, 0, 16'h0, 2'b0, "R9");
    step(0, 0, 0, 1, 16'h5001, 2'b00, 1, 16'h5002, 2'b00, "R9");
    step(0, 1, 0, 1, 16'h5003, 2'b00, 0, 16'h0, 2'b0, "R9");
    step(0, 0, 0, 1, 16'h5004, 2'b00, 1, 16'h5005, 2'b00, "R9");
    idle("R9");
    // R9: stop after even count, no error
    step(1, 0, 2'd1, 0, 16'h0, 2'b0, 0, 16'h0, 2'b0, "R9");
    step(0, 1, 0, 1, 16'h6001, 2'b00, 1, 16'h6002, 2'b00, "R9");
    step(0, 0, 0, 1, 16'h6003, 2'b00, 1, 16'h6004, 2'b00, "R9");
    // R10: write and stop together, write wins; bl_sel 3 means 8 beats (R5)
    step(1, 1, 2'd3, 0, 16'h0, 2'b0, 0, 16'h0, 2'b0, "R10");
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 0, 1, 16'(16'h7000 + 2*i), 2'(i), 1, 16'(16'h7001 + 2*i), 2'(3 - i), "R10");
    end
    idle("R10");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule